// File: doc/BRIEF.md
# Peripheral Access Gate with Security and Privilege Filtering

The gate sits between one bus master and up to `NPORT` peripheral ports. Each request arrives with the index of the target port, an address, a write flag, write data, an access size, and two attributes: secure and unprivileged. Every request is checked against two per-port configuration bits. The first is a non-secure marking. The second permits unprivileged access. There is also a build-time exemption mask that lets chosen ports skip the security comparison. An allowed request goes out unchanged to the selected port, and that port's reply comes back to the master unchanged. A refused request never reaches any port. The gate answers it locally: an error if the global response-mode input is high, or a quiet success (reads give zero, writes are discarded) if it is low.

Each refusal sets a sticky violation flag. A level-sensitive clear input holds that flag at zero. The interrupt output is the flag gated by an enable input. One transaction is in flight at a time, so replies come back in request order. Choosing the port from the address is the job of the surrounding fabric.

Top module: `periph_sec_gate`

## Requirements
- R1: After reset, `up_req_ready` is 1 and `up_rsp_valid`, every `dn_req_valid` bit and `irq` are 0.
- R2: The configuration inputs (`cfg_nonsec`, `cfg_unpriv_ok`, `cfg_err_resp`) are registered each cycle and reset to 0. A request accepted on the same edge as a change still sees the previous values.
- R3: A request to port p is refused when `up_req_secure` equals `cfg_nonsec[p]`, unless bit p of `EXEMPT_MASK` is set.
- R4: A request with `up_req_unpriv`=1 to port p is refused when `cfg_unpriv_ok[p]` is 0, whatever its security attribute.
- R5: An allowed request raises only `dn_req_valid[p]`, with address, write flag, write data (little-endian: byte k on bits 8k+7:8k), size code (0=1, 1=2, 2=4, 3=8 bytes) and attributes unchanged. The port's `dn_rsp_err` and `dn_rsp_rdata` come back on the upstream response one cycle after its `dn_rsp_valid`.
- R6: A refused request raises no `dn_req_valid` bit.
- R7: A refused request gets `up_rsp_valid`=1 in the cycle after acceptance. When `cfg_err_resp` was 1, `up_rsp_err` is 1.
- R8: When `cfg_err_resp` was 0, a refused request gets `up_rsp_err`=0 and `up_rsp_rdata`=0, and a refused write reaches no port.
- R9: `up_req_ready` is 0 from acceptance until the cycle after the response, and it is never 1 together with `up_rsp_valid`.
- R10: A refused request accepted while `irq_clr` is 0 sets the violation flag. The flag stays set, across any number of later accesses, until it is cleared.
- R11: While `irq_clr` is 1, the flag is forced to 0 on every edge and refused requests do not set it.
- R12: `irq` equals the flag AND `irq_en`, combinationally, so a change of `irq_en` shows on `irq` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_nonsec | input | NPORT | Per-port non-secure marking |
| cfg_unpriv_ok | input | NPORT | Per-port unprivileged permission |
| cfg_err_resp | input | 1 | 1: refuse with error; 0: quiet success |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Level clear of the violation flag |
| irq | output | 1 | Violation interrupt |
| up_req_valid | input | 1 | Master request valid |
| up_req_ready | output | 1 | Gate can accept a request |
| up_req_port | input | PORT_W | Target port index |
| up_req_addr | input | ADDR_W | Request address |
| up_req_write | input | 1 | 1 = write |
| up_req_wdata | input | DATA_W | Write data |
| up_req_size | input | 2 | Size code |
| up_req_secure | input | 1 | Secure attribute |
| up_req_unpriv | input | 1 | Unprivileged attribute |
| up_rsp_valid | output | 1 | Response valid (one cycle) |
| up_rsp_err | output | 1 | Error response |
| up_rsp_rdata | output | DATA_W | Read data |
| dn_req_valid | output | NPORT | Per-port request valid |
| dn_req_ready | input | NPORT | Per-port request ready |
| dn_req_addr | output | ADDR_W | Forwarded address |
| dn_req_write | output | 1 | Forwarded write flag |
| dn_req_wdata | output | DATA_W | Forwarded write data |
| dn_req_size | output | 2 | Forwarded size code |
| dn_req_secure | output | 1 | Forwarded secure attribute |
| dn_req_unpriv | output | 1 | Forwarded unprivileged attribute |
| dn_rsp_valid | input | NPORT | Per-port response valid |
| dn_rsp_err | input | NPORT | Per-port response error |
| dn_rsp_rdata | input | NPORT x DATA_W | Per-port read data |

## Verification
The properties rely on three things about the surroundings. A peripheral answers only after its request handshake. It answers exactly once. No port replies while the gate is not waiting on it. The bench's peripheral model keeps to all three: it holds ready high, answers exactly one cycle after each handshake, and reports a protocol error if a request shows up that the scoreboard did not predict as forwarded. The master side waits for `up_req_ready`, and it changes configuration only between transactions, except in the one deliberate same-edge case that tests R2.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } gate_state_e;

    // Access size code: number of bytes is 1 << code
    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } access_size_e;

endpackage

// File: rtl/sec_gate_cfg.sv
module sec_gate_cfg #(
    parameter int NPORT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] nonsec_i,
    input  logic [NPORT-1:0] unpriv_ok_i,
    input  logic             err_mode_i,
    output logic [NPORT-1:0] nonsec_q,
    output logic [NPORT-1:0] unpriv_ok_q,
    output logic             err_mode_q
);

    typedef struct packed {
        logic [NPORT-1:0] nonsec;
        logic [NPORT-1:0] unpriv_ok;
        logic             err_mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d           = cfg_q;
        cfg_d.nonsec    = nonsec_i;
        cfg_d.unpriv_ok = unpriv_ok_i;
        cfg_d.err_mode  = err_mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign nonsec_q    = cfg_q.nonsec;
    assign unpriv_ok_q = cfg_q.unpriv_ok;
    assign err_mode_q  = cfg_q.err_mode;

endmodule

// File: rtl/sec_gate_check.sv
module sec_gate_check #(
    parameter int               NPORT       = 16,
    parameter int               PORT_W      = 4,
    parameter logic [NPORT-1:0] EXEMPT_MASK = '0
) (
    input  logic [PORT_W-1:0] port_i,
    input  logic              secure_i,
    input  logic              unpriv_i,
    input  logic [NPORT-1:0]  nonsec_i,
    input  logic [NPORT-1:0]  unpriv_ok_i,
    output logic              blocked_o
);

    logic [NPORT-1:0] deny_vec;
    logic             in_range;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        logic sec_fail;
        logic priv_fail;
        if (EXEMPT_MASK[i]) begin : g_exempt
            assign sec_fail = 1'b0;
        end else begin : g_checked
            assign sec_fail = (secure_i == nonsec_i[i]);
        end
        assign priv_fail   = unpriv_i && !unpriv_ok_i[i];
        assign deny_vec[i] = sec_fail || priv_fail;
    end

    if (NPORT == (1 << PORT_W)) begin : g_full_range
        assign in_range = 1'b1;
    end else begin : g_part_range
        assign in_range = ({{(32-PORT_W){1'b0}}, port_i} < 32'(NPORT));
    end

    assign blocked_o = !in_range || deny_vec[port_i];

endmodule

// File: rtl/sec_gate_irq.sv
module sec_gate_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic violation_i,
    input  logic clear_i,
    input  logic enable_i,
    output logic status_o,
    output logic irq_o
);

    logic status_d, status_q;

    always_comb begin
        status_d = status_q;
        if (clear_i)          status_d = 1'b0;
        else if (violation_i) status_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= 1'b0;
        else        status_q <= status_d;
    end

    assign status_o = status_q;
    assign irq_o    = status_q && enable_i;

endmodule

// File: rtl/periph_sec_gate.sv
module periph_sec_gate
    import sec_gate_pkg::*;
#(
    parameter int               NPORT       = 16,
    parameter int               ADDR_W      = 32,
    parameter int               DATA_W      = 64,
    parameter logic [NPORT-1:0] EXEMPT_MASK = '0,
    localparam int              PORT_W      = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0]             cfg_nonsec,
    input  logic [NPORT-1:0]             cfg_unpriv_ok,
    input  logic                         cfg_err_resp,
    input  logic                         irq_en,
    input  logic                         irq_clr,
    output logic                         irq,
    input  logic                         up_req_valid,
    output logic                         up_req_ready,
    input  logic [PORT_W-1:0]            up_req_port,
    input  logic [ADDR_W-1:0]            up_req_addr,
    input  logic                         up_req_write,
    input  logic [DATA_W-1:0]            up_req_wdata,
    input  logic [1:0]                   up_req_size,
    input  logic                         up_req_secure,
    input  logic                         up_req_unpriv,
    output logic                         up_rsp_valid,
    output logic                         up_rsp_err,
    output logic [DATA_W-1:0]            up_rsp_rdata,
    output logic [NPORT-1:0]             dn_req_valid,
    input  logic [NPORT-1:0]             dn_req_ready,
    output logic [ADDR_W-1:0]            dn_req_addr,
    output logic                         dn_req_write,
    output logic [DATA_W-1:0]            dn_req_wdata,
    output logic [1:0]                   dn_req_size,
    output logic                         dn_req_secure,
    output logic                         dn_req_unpriv,
    input  logic [NPORT-1:0]             dn_rsp_valid,
    input  logic [NPORT-1:0]             dn_rsp_err,
    input  logic [NPORT-1:0][DATA_W-1:0] dn_rsp_rdata
);

    typedef struct packed {
        gate_state_e       state;
        logic [PORT_W-1:0] port;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
        access_size_e      size;
        logic              secure;
        logic              unpriv;
        logic              rsp_err;
        logic [DATA_W-1:0] rsp_rdata;
    } gate_regs_t;

    gate_regs_t r_d, r_q;

    logic [NPORT-1:0] nonsec_q;
    logic [NPORT-1:0] unpriv_ok_q;
    logic             err_mode_q;
    logic             req_blocked;
    logic             accept;
    logic             irq_status;

    sec_gate_cfg #(.NPORT(NPORT)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .nonsec_i    (cfg_nonsec),
        .unpriv_ok_i (cfg_unpriv_ok),
        .err_mode_i  (cfg_err_resp),
        .nonsec_q    (nonsec_q),
        .unpriv_ok_q (unpriv_ok_q),
        .err_mode_q  (err_mode_q)
    );

    sec_gate_check #(
        .NPORT       (NPORT),
        .PORT_W      (PORT_W),
        .EXEMPT_MASK (EXEMPT_MASK)
    ) u_check (
        .port_i      (up_req_port),
        .secure_i    (up_req_secure),
        .unpriv_i    (up_req_unpriv),
        .nonsec_i    (nonsec_q),
        .unpriv_ok_i (unpriv_ok_q),
        .blocked_o   (req_blocked)
    );

    assign accept = up_req_valid && (r_q.state == ST_IDLE);

    sec_gate_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .violation_i (accept && req_blocked),
        .clear_i     (irq_clr),
        .enable_i    (irq_en),
        .status_o    (irq_status),
        .irq_o       (irq)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (up_req_valid) begin
                    r_d.port   = up_req_port;
                    r_d.addr   = up_req_addr;
                    r_d.write  = up_req_write;
                    r_d.wdata  = up_req_wdata;
                    r_d.size   = access_size_e'(up_req_size);
                    r_d.secure = up_req_secure;
                    r_d.unpriv = up_req_unpriv;
                    if (req_blocked) begin
                        // answered locally, never forwarded
                        r_d.state     = ST_RESP;
                        r_d.rsp_err   = err_mode_q;
                        r_d.rsp_rdata = '0;
                    end else begin
                        r_d.state = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (dn_req_ready[r_q.port]) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (dn_rsp_valid[r_q.port]) begin
                    r_d.state     = ST_RESP;
                    r_d.rsp_err   = dn_rsp_err[r_q.port];
                    r_d.rsp_rdata = dn_rsp_rdata[r_q.port];
                end
            end
            ST_RESP: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_dn_valid
        assign dn_req_valid[i] = (r_q.state == ST_ISSUE) && (r_q.port == PORT_W'(i));
    end

    assign up_req_ready  = (r_q.state == ST_IDLE);
    assign up_rsp_valid  = (r_q.state == ST_RESP);
    assign up_rsp_err    = r_q.rsp_err;
    assign up_rsp_rdata  = r_q.rsp_rdata;
    assign dn_req_addr   = r_q.addr;
    assign dn_req_write  = r_q.write;
    assign dn_req_wdata  = r_q.wdata;
    assign dn_req_size   = r_q.size;
    assign dn_req_secure = r_q.secure;
    assign dn_req_unpriv = r_q.unpriv;

endmodule

// File: rtl/sec_gate_chk.sv
module sec_gate_chk #(
    parameter int NPORT  = 16,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_req_valid,
    input logic              up_req_ready,
    input logic              up_rsp_valid,
    input logic              up_rsp_err,
    input logic [DATA_W-1:0] up_rsp_rdata,
    input logic [NPORT-1:0]  dn_req_valid,
    input logic              req_blocked,
    input logic              err_mode_q,
    input logic              irq_en,
    input logic              irq_clr,
    input logic              irq
);

    logic acc_blk;
    assign acc_blk = up_req_valid && up_req_ready && req_blocked;

    assert_dn_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_req_valid));

    assert_blocked_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_blk |=> (up_rsp_valid && dn_req_valid == '0));

    assert_blocked_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_blk && err_mode_q) |=> up_rsp_err);

    assert_blocked_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_blk && !err_mode_q) |=> (!up_rsp_err && up_rsp_rdata == '0));

    assert_single_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        up_rsp_valid |-> !up_req_ready);

    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_blk && !irq_clr) |=> (irq || !irq_en));

    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> (irq || !irq_en));

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> !irq);

endmodule

bind periph_sec_gate sec_gate_chk #(.NPORT(NPORT), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_req_valid (up_req_valid),
    .up_req_ready (up_req_ready),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_err   (up_rsp_err),
    .up_rsp_rdata (up_rsp_rdata),
    .dn_req_valid (dn_req_valid),
    .req_blocked  (req_blocked),
    .err_mode_q   (err_mode_q),
    .irq_en       (irq_en),
    .irq_clr      (irq_clr),
    .irq          (irq)
);

// File: tb/periph_sec_gate_tb.sv
module periph_sec_gate_tb;

    localparam int          NP     = 16;
    localparam int          AW     = 32;
    localparam int          DW     = 64;
    localparam logic [15:0] EXEMPT = 16'h8000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NP-1:0]          cfg_nonsec = '0, cfg_unpriv_ok = '0;
    logic                   cfg_err_resp = 1'b0, irq_en = 1'b0, irq_clr = 1'b0, irq;
    logic                   up_req_valid = 1'b0, up_req_ready;
    logic [3:0]             up_req_port = '0;
    logic [AW-1:0]          up_req_addr = '0;
    logic                   up_req_write = 1'b0;
    logic [DW-1:0]          up_req_wdata = '0;
    logic [1:0]             up_req_size = '0;
    logic                   up_req_secure = 1'b0, up_req_unpriv = 1'b0;
    logic                   up_rsp_valid, up_rsp_err;
    logic [DW-1:0]          up_rsp_rdata;
    logic [NP-1:0]          dn_req_valid;
    logic [NP-1:0]          dn_req_ready = '1;
    logic [AW-1:0]          dn_req_addr;
    logic                   dn_req_write;
    logic [DW-1:0]          dn_req_wdata;
    logic [1:0]             dn_req_size;
    logic                   dn_req_secure, dn_req_unpriv;
    logic [NP-1:0]          dn_rsp_valid = '0, dn_rsp_err = '0;
    logic [NP-1:0][DW-1:0]  dn_rsp_rdata = '0;

    periph_sec_gate #(.NPORT(NP), .ADDR_W(AW), .DATA_W(DW), .EXEMPT_MASK(EXEMPT)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_nonsec(cfg_nonsec), .cfg_unpriv_ok(cfg_unpriv_ok), .cfg_err_resp(cfg_err_resp),
        .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq),
        .up_req_valid(up_req_valid), .up_req_ready(up_req_ready), .up_req_port(up_req_port),
        .up_req_addr(up_req_addr), .up_req_write(up_req_write), .up_req_wdata(up_req_wdata),
        .up_req_size(up_req_size), .up_req_secure(up_req_secure), .up_req_unpriv(up_req_unpriv),
        .up_rsp_valid(up_rsp_valid), .up_rsp_err(up_rsp_err), .up_rsp_rdata(up_rsp_rdata),
        .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready), .dn_req_addr(dn_req_addr),
        .dn_req_write(dn_req_write), .dn_req_wdata(dn_req_wdata), .dn_req_size(dn_req_size),
        .dn_req_secure(dn_req_secure), .dn_req_unpriv(dn_req_unpriv),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_err(dn_rsp_err), .dn_rsp_rdata(dn_rsp_rdata)
    );

    typedef struct {
        int            port;
        logic [AW-1:0] addr;
        logic          wr;
        logic [DW-1:0] wdata;
        logic [1:0]    size;
        logic          sec;
        logic          upr;
    } fwd_t;

    typedef struct {
        logic          err;
        logic [DW-1:0] rdata;
        string         tag;
    } rsp_t;

    fwd_t fwd_q[$];
    rsp_t rsp_q[$];

    int n_chk = 0;
    int n_fail = 0;
    int n_rsp = 0;
    bit m_status = 1'b0;

    function automatic logic [DW-1:0] periph_data(int p, logic [AW-1:0] a);
        return {16'hC0DE, 12'(p), a, 4'h5};
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_irq(string tag);
        check(tag, 64'(irq), 64'(m_status && irq_en));
    endtask

    // Driver: called at a falling edge; returns at a falling edge after the response
    task automatic issue(int p, logic [AW-1:0] a, bit wr, logic [DW-1:0] wd, logic [1:0] sz,
                         bit sec, bit upr, int err_ovr, string tag);
        bit   blk;
        logic errm;
        int   seen;
        int   guard;
        while (up_req_ready !== 1'b1) @(negedge clk);
        blk  = ((sec == cfg_nonsec[p]) && !EXEMPT[p]) || (upr && !cfg_unpriv_ok[p]);
        errm = (err_ovr < 0) ? cfg_err_resp : err_ovr[0];
        if (blk) begin
            rsp_q.push_back('{err: errm, rdata: '0, tag: tag});
            if (!irq_clr) m_status = 1'b1;
        end else begin
            fwd_q.push_back('{port: p, addr: a, wr: wr, wdata: wd, size: sz, sec: sec, upr: upr});
            rsp_q.push_back('{err: (a[3:0] == 4'hE), rdata: periph_data(p, a), tag: tag});
        end
        up_req_valid  = 1'b1;
        up_req_port   = 4'(p);
        up_req_addr   = a;
        up_req_write  = wr;
        up_req_wdata  = wd;
        up_req_size   = sz;
        up_req_secure = sec;
        up_req_unpriv = upr;
        seen = n_rsp;
        @(negedge clk);
        up_req_valid = 1'b0;
        if (blk) check({tag, " R7 local response timing"}, 64'(up_rsp_valid), 64'd1);
        guard = 0;
        while (n_rsp == seen && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        if (n_rsp == seen) check({tag, " R9 response missing"}, 64'd0, 64'd1);
    endtask

    // Monitor: scoreboard compare of upstream responses
    initial begin
        forever begin
            @(negedge clk);
            if (up_rsp_valid === 1'b1) begin
                if (rsp_q.size() == 0) begin
                    check("R9 unexpected response", 64'd1, 64'd0);
                end else begin
                    rsp_t e;
                    e = rsp_q.pop_front();
                    check({e.tag, " err"}, 64'(up_rsp_err), 64'(e.err));
                    check({e.tag, " rdata"}, up_rsp_rdata, e.rdata);
                    check("R9 ready low with response", 64'(up_req_ready), 64'd0);
                end
                n_rsp++;
            end
        end
    end

    // Peripheral model: always ready, answers one cycle after the handshake
    initial begin
        bit            pend;
        int            pp;
        logic [AW-1:0] pa;
        pend = 1'b0;
        pp = 0;
        pa = '0;
        forever begin
            @(negedge clk);
            dn_rsp_valid = '0;
            dn_rsp_err   = '0;
            if (pend) begin
                dn_rsp_valid[pp] = 1'b1;
                dn_rsp_err[pp]   = (pa[3:0] == 4'hE);
                dn_rsp_rdata[pp] = periph_data(pp, pa);
                pend = 1'b0;
            end
            if (dn_req_valid != '0) begin
                int idx;
                idx = 0;
                for (int i = 0; i < NP; i++) if (dn_req_valid[i]) idx = i;
                if (fwd_q.size() == 0) begin
                    check("R6 refused access reached a port", 64'(dn_req_valid), 64'd0);
                end else begin
                    fwd_t f;
                    f = fwd_q.pop_front();
                    check("R5 port select", 64'(dn_req_valid), 64'(1) << f.port);
                    check("R5 addr", 64'(dn_req_addr), 64'(f.addr));
                    check("R5 write", 64'(dn_req_write), 64'(f.wr));
                    check("R5 wdata", dn_req_wdata, f.wdata);
                    check("R5 size", 64'(dn_req_size), 64'(f.size));
                    check("R5 attrs", 64'({dn_req_secure, dn_req_unpriv}), 64'({f.sec, f.upr}));
                end
                pend = 1'b1;
                pp   = idx;
                pa   = dn_req_addr;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 64'(up_req_ready), 64'd1);
        check("R1 rsp valid", 64'(up_rsp_valid), 64'd0);
        check("R1 dn valid", 64'(dn_req_valid), 64'd0);
        check("R1 irq", 64'(irq), 64'd0);

        // R3 with reset configuration (all ports secure-only)
        issue(3, 32'h100, 1'b0, '0, 2'd2, 1'b1, 1'b0, -1, "R3 secure allowed");
        issue(3, 32'h104, 1'b1, 64'h1122, 2'd1, 1'b0, 1'b0, -1, "R3 R8 nonsecure refused quiet");
        check_irq("R12 irq masked");
        irq_en = 1'b1;
        #1 check_irq("R12 enable shows at once");
        irq_en = 1'b0;
        #1 check_irq("R12 disable shows at once");
        irq_en = 1'b1;
        issue(3, 32'h108, 1'b0, '0, 2'd3, 1'b1, 1'b0, -1, "R10 later access");
        issue(7, 32'h10C, 1'b1, 64'h33, 2'd0, 1'b1, 1'b0, -1, "R10 later access");
        check_irq("R10 flag sticky");

        // R11 level clear
        irq_clr = 1'b1;
        @(negedge clk);
        m_status = 1'b0;
        check_irq("R11 clear forces zero");
        issue(3, 32'h110, 1'b0, '0, 2'd2, 1'b0, 1'b0, -1, "R11 refused during clear");
        check_irq("R11 no set during clear");
        irq_clr = 1'b0;
        @(negedge clk);
        check_irq("R11 stays zero after clear");

        // R3 non-secure port
        cfg_nonsec[3] = 1'b1;
        @(negedge clk);
        issue(3, 32'h200, 1'b0, '0, 2'd2, 1'b0, 1'b0, -1, "R3 nonsecure port nonsecure access");
        issue(3, 32'h204, 1'b0, '0, 2'd2, 1'b1, 1'b0, -1, "R3 nonsecure port secure access");
        check_irq("R10 set by refusal");
        // R3 exemption mask (port 15 exempt, port 14 not)
        issue(15, 32'h300, 1'b0, '0, 2'd2, 1'b0, 1'b0, -1, "R3 exempt nonsecure");
        issue(15, 32'h304, 1'b0, '0, 2'd2, 1'b1, 1'b0, -1, "R3 exempt secure");
        issue(14, 32'h308, 1'b0, '0, 2'd2, 1'b0, 1'b0, -1, "R3 unexempt refused");

        // R4 privilege
        issue(3, 32'h400, 1'b0, '0, 2'd2, 1'b0, 1'b1, -1, "R4 unpriv refused");
        issue(15, 32'h404, 1'b0, '0, 2'd2, 1'b0, 1'b1, -1, "R4 unpriv refused on exempt port");
        cfg_unpriv_ok[3] = 1'b1;
        @(negedge clk);
        issue(3, 32'h408, 1'b1, 64'hABCD, 2'd3, 1'b0, 1'b1, -1, "R4 unpriv permitted");

        // R2 same-edge change keeps the old response mode, then R7 error mode
        @(negedge clk);
        cfg_err_resp = 1'b1;
        issue(3, 32'h500, 1'b0, '0, 2'd2, 1'b1, 1'b0, 0, "R2 old mode used");
        issue(3, 32'h504, 1'b1, 64'hDEAD, 2'd2, 1'b1, 1'b0, -1, "R7 R6 refused write error");
        issue(3, 32'h508, 1'b0, '0, 2'd2, 1'b1, 1'b0, -1, "R7 refused read error");

        // R5 peripheral error returned, all size codes
        issue(3, 32'h60E, 1'b0, '0, 2'd2, 1'b0, 1'b0, -1, "R5 peripheral error");
        for (int s = 0; s < 4; s++)
            issue(15, 32'h700 + 32'(s * 8), 1'b1, 64'h0807060504030201 << (s * 8), 2'(s),
                  1'b1, 1'b0, -1, "R5 size and byte lanes");

        // R3 R4 sweep over every port and attribute combination
        cfg_nonsec    = 16'hAAAA;
        cfg_unpriv_ok = 16'hCCCC;
        for (int p = 0; p < NP; p++) begin
            cfg_err_resp = p[2];
            @(negedge clk);
            for (int c = 0; c < 4; c++)
                issue(p, 32'h4000_0000 | 32'(p << 8) | 32'(c << 4) | ((c == 3) ? 32'hE : 32'h0),
                      c[0], 64'(p * 4 + c), 2'(c), c[1], c[0], -1, "R3 R4 sweep");
        end
        check_irq("R10 after sweep");
        check("R6 no leftover forwards", 64'(fwd_q.size()), 64'd0);
        check("R9 no leftover responses", 64'(rsp_q.size()), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule